// File: doc/BRIEF.md
# Synchronized Duty-Cycled MAC Controller

This block is the link-layer sequencer of a low-power radio node in a network where every node wakes at the same instants. A once-per-second pulse from an externally disciplined real-time clock starts each wakeup. With nothing queued, the node opens its receiver for a short listen window of two bit times (Manchester-coded on-off keying needs two bit times to reveal a carrier). If the window stays quiet, the node returns to sleep. If carrier appears, the node stays awake, takes a frame, and sends an acknowledgement only when the frame names it as destination.

With a frame queued, the node first checks the channel for the same window. It defers by a pseudo-random slot while the channel is busy. It then sends a preamble, the data frame, and waits for the acknowledgement. Because all nodes share one time base, the preamble only has to cover worst-case clock skew rather than a full wakeup period. The host loads the skew term (four times the per-node skew, in bit times) and the controller adds the listen window on top. Time inside the block is counted in bit times derived from the system clock.

Frames are byte streams. Data frame byte 0 is the destination address and byte 1 the source address. Acknowledgement byte 0 is the address of the node being acknowledged and byte 1 the acknowledging node's own address. The remaining acknowledgement bytes are zero.

Top module: `mac_sync_duty_ctrl`

## Requirements
- R1: After reset the radio is off, no preamble or transmit strobe is produced, and the node sleeps until a wakeup pulse.
- R2: A wakeup with nothing pending keeps `radio_en_o` high for exactly LISTEN_BITS bit times (8 clocks by default) when carrier sense stays low, then sleeps.
- R3: A wakeup pulse that arrives while the node is already awake has no effect; the listen window is not extended.
- R4: With a frame pending, the channel is sensed for LISTEN_BITS bit times after the wakeup. If it stays clear, `air_pre_o` is then high for exactly `pre_len_i` + LISTEN_BITS bit times.
- R5: Carrier seen while sensing defers the node by a slot of 1 to 15 bit times, taken from a free-running 4-bit LFSR, after which it senses again. No preamble starts while the channel is busy.
- R6: After the preamble, FRAME_BYTES data bytes leave on `air_tx_stb_o`, one every 8 bit times. Byte k is the value of `tx_byte_i` while `tx_idx_o` = k.
- R7: If ACK_BYTES bytes arrive within the acknowledgement timeout and the first equals `my_addr_i`, `done_o` pulses with `ok_o` high.
- R8: If no valid acknowledgement arrives within ACK_BYTES*8 + 4 bit times after the last data byte, `fail_o` pulses. The send is retried at the next wakeup. The third failure also pulses `done_o` with `ok_o` low.
- R9: On carrier in the listen window the node stays awake. When data byte 0 equals `my_addr_i`, every byte of the frame is passed to `rx_stb_o`/`rx_byte_o`. An acknowledgement of ACK_BYTES bytes is then sent: source address, own address, then zeros.
- R10: A frame whose destination byte is another address is not forwarded and not acknowledged, and the node sleeps after its last byte.
- R11: In receive, a gap of 2^PRE_W + LISTEN_BITS + 16 bit times without a byte returns the node to sleep.
- R12: Received byte strobes while asleep are ignored: nothing is forwarded, nothing is sent and the radio stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_tick_i | input | 1 | One-cycle pulse on each synchronized wakeup instant |
| cs_i | input | 1 | Carrier sense from the radio |
| pend_i | input | 1 | Host has a data frame queued |
| pre_len_i | input | PRE_W | Skew part of the preamble, in bit times |
| my_addr_i | input | 8 | Own node address |
| tx_idx_o | output | 8 | Index of the byte the controller is sending |
| tx_byte_i | input | 8 | Host data byte for index `tx_idx_o` |
| air_rx_stb_i | input | 1 | Radio delivered one byte |
| air_rx_byte_i | input | 8 | Byte delivered by the radio |
| air_tx_stb_o | output | 1 | One byte handed to the radio |
| air_tx_byte_o | output | 8 | Byte handed to the radio |
| air_pre_o | output | 1 | Radio sends preamble |
| radio_en_o | output | 1 | Radio powered |
| tx_on_o | output | 1 | Radio in transmit direction |
| rx_stb_o | output | 1 | Forwarded byte of a frame for this node |
| rx_byte_o | output | 8 | Forwarded byte |
| fail_o | output | 1 | One send attempt failed |
| done_o | output | 1 | Send finished, outcome on `ok_o` |
| ok_o | output | 1 | Acknowledged, valid with `done_o` |

## Verification
The bench measures the preamble length to the clock and the gap from the wakeup to its start. An off-by-one in the preamble counter or a missing listen-window addition shows up as a wrong cycle count. It holds the channel busy across a wakeup, so a sender that ignores carrier would start its preamble early. A sender that defers without bound would miss the window allowed after the channel clears. It times the failure pulse against the last data byte to expose a wrong acknowledgement timeout, and it counts retries so that a wrong attempt limit shows as a missing or early final outcome. On the receive side it checks that overheard frames are neither forwarded nor acknowledged, that the receive gap timeout has its exact length, and that bytes arriving while asleep are dropped.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
// Shared types of the synchronized duty-cycled MAC controller.
// Assumes: nothing; pure type definitions.
package mac_pkg;

    typedef enum logic [3:0] {
        ST_SLEEP,
        ST_LISTEN,
        ST_RX,
        ST_ACK_TX,
        ST_SENSE,
        ST_BACKOFF,
        ST_PRE,
        ST_DATA,
        ST_WAIT_ACK
    } mac_state_t;

endpackage

// File: rtl/mac_bit_timer.sv
`timescale 1ns/1ps
// Bit-time base: divides the clock into bit strobes and counts the bit
// times elapsed since the last clear.
// Assumes: clr_i is asserted in the cycle before a new interval starts, so
// the first bit of an interval ends CLK_PER_BIT cycles after entry.
module mac_bit_timer #(
    parameter int CLK_PER_BIT = 4,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic             bit_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int PW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

    logic [PW-1:0] pcnt_q;

    assign bit_o = (pcnt_q == PW'(CLK_PER_BIT - 1));

    // Prescaler and bit counter, both restarted by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt_q <= '0;
            cnt_o  <= '0;
        end else if (bit_o) begin
            pcnt_q <= '0;
            cnt_o  <= cnt_o + 1'b1;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_CNT_HOLDS_BETWEEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !bit_o) |=> $stable(cnt_o)); // R2

endmodule

// File: rtl/mac_slot_lfsr.sv
`timescale 1ns/1ps
// Free-running Fibonacci LFSR that supplies the random contention slot.
// Assumes: W between 3 and 8; the all-zero state is never reached.
module mac_slot_lfsr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] slot_o
);
    // Feedback bit for a maximal-length sequence of the chosen width.
    function automatic logic fb(input logic [W-1:0] s);
        case (W)
            5:       fb = s[W-1] ^ s[2];
            8:       fb = s[7] ^ s[5] ^ s[4] ^ s[3];
            default: fb = s[W-1] ^ s[W-2];
        endcase
    endfunction

    // Advance one step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_o <= W'(1);
        else        slot_o <= {slot_o[W-2:0], fb(slot_o)};
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o != '0); // R5

endmodule

// File: rtl/mac_sync_duty_ctrl.sv
`timescale 1ns/1ps
// Synchronized duty-cycled MAC controller.
// Wakes on a shared time pulse, listens, or sends preamble + data and
// waits for an acknowledgement; receives and acknowledges frames addressed
// to this node. Time is counted in bit times from mac_bit_timer.
// Assumes: pre_len_i and my_addr_i are stable while awake; FRAME_BYTES and
// ACK_BYTES are at least 2 and at most 256; one received byte per strobe.
module mac_sync_duty_ctrl
    import mac_pkg::*;
#(
    parameter int CLK_PER_BIT    = 4,
    parameter int LISTEN_BITS    = 2,
    parameter int PRE_W          = 8,
    parameter int FRAME_BYTES    = 20,
    parameter int ACK_BYTES      = 20,
    parameter int ACK_SLACK_BITS = 4,
    parameter int MAX_TRIES      = 3,
    parameter int SLOT_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_tick_i,
    input  logic             cs_i,
    input  logic             pend_i,
    input  logic [PRE_W-1:0] pre_len_i,
    input  logic [7:0]       my_addr_i,
    output logic [7:0]       tx_idx_o,
    input  logic [7:0]       tx_byte_i,
    input  logic             air_rx_stb_i,
    input  logic [7:0]       air_rx_byte_i,
    output logic             air_tx_stb_o,
    output logic [7:0]       air_tx_byte_o,
    output logic             air_pre_o,
    output logic             radio_en_o,
    output logic             tx_on_o,
    output logic             rx_stb_o,
    output logic [7:0]       rx_byte_o,
    output logic             fail_o,
    output logic             done_o,
    output logic             ok_o
);
    localparam int FRAME_BITS    = FRAME_BYTES * 8;
    localparam int ACK_BITS      = ACK_BYTES * 8;
    localparam int ACK_WAIT_BITS = ACK_BITS + ACK_SLACK_BITS;
    localparam int GAP_BITS      = (1 << PRE_W) + LISTEN_BITS + 16;
    localparam int MAX_A         = (FRAME_BITS > ACK_WAIT_BITS) ? FRAME_BITS : ACK_WAIT_BITS;
    localparam int MAX_BITS      = (MAX_A > GAP_BITS) ? MAX_A : GAP_BITS;
    localparam int CNT_W         = $clog2(MAX_BITS + 1);
    localparam int MAX_BYTES     = (FRAME_BYTES > ACK_BYTES) ? FRAME_BYTES : ACK_BYTES;
    localparam int RC_W          = $clog2(MAX_BYTES + 1);
    localparam int TRY_W         = $clog2(MAX_TRIES + 1);

    mac_state_t        state_q, state_d;
    logic              bit_s;
    logic [CNT_W-1:0]  tcnt;
    logic              clr;
    logic [SLOT_W-1:0] lfsr;
    logic [SLOT_W-1:0] slot_q;
    logic [RC_W-1:0]   rcnt_q;
    logic              hit_q;
    logic [7:0]        src_q;
    logic [TRY_W-1:0]  try_q;
    logic              hit_now;
    logic              listen_end, pre_end, byte_end;
    logic              ack_ok, ack_to;
    logic [7:0]        idx;
    logic [7:0]        ack_byte;

    mac_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .bit_o (bit_s),
        .cnt_o (tcnt)
    );

    mac_slot_lfsr #(.W(SLOT_W)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (lfsr)
    );

    // Interval events derived from the bit counter.
    assign listen_end = bit_s && (tcnt == CNT_W'(LISTEN_BITS - 1));
    assign pre_end    = bit_s && (tcnt == CNT_W'(pre_len_i) + CNT_W'(LISTEN_BITS - 1));
    assign byte_end   = bit_s && (tcnt[2:0] == 3'd7);
    assign hit_now    = (rcnt_q == '0) ? (air_rx_byte_i == my_addr_i) : hit_q;
    assign ack_ok     = (state_q == ST_WAIT_ACK) && air_rx_stb_i &&
                        (rcnt_q == RC_W'(ACK_BYTES - 1)) && hit_now;
    assign ack_to     = (state_q == ST_WAIT_ACK) && !ack_ok && bit_s &&
                        (tcnt == CNT_W'(ACK_WAIT_BITS - 1));

    // Byte index within the frame being sent, and the acknowledgement content.
    assign idx      = 8'(tcnt >> 3);
    assign tx_idx_o = idx;
    assign ack_byte = (idx == 8'd0) ? src_q : (idx == 8'd1) ? my_addr_i : 8'h00;

    // Next-state selection of the sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_SLEEP:    if (wake_tick_i) state_d = pend_i ? ST_SENSE : ST_LISTEN;
            ST_LISTEN:   if (cs_i) state_d = ST_RX;
                         else if (listen_end) state_d = ST_SLEEP;
            ST_RX:       if (air_rx_stb_i && (rcnt_q == RC_W'(FRAME_BYTES - 1)))
                             state_d = hit_q ? ST_ACK_TX : ST_SLEEP;
                         else if (bit_s && (tcnt == CNT_W'(GAP_BITS - 1)))
                             state_d = ST_SLEEP;
            ST_ACK_TX:   if (bit_s && (tcnt == CNT_W'(ACK_BITS - 1))) state_d = ST_SLEEP;
            ST_SENSE:    if (cs_i) state_d = ST_BACKOFF;
                         else if (listen_end) state_d = ST_PRE;
            ST_BACKOFF:  if (bit_s && (tcnt == CNT_W'(slot_q) - CNT_W'(1))) state_d = ST_SENSE;
            ST_PRE:      if (pre_end) state_d = ST_DATA;
            ST_DATA:     if (bit_s && (tcnt == CNT_W'(FRAME_BITS - 1))) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (ack_ok || ack_to) state_d = ST_SLEEP;
            default:     state_d = ST_SLEEP;
        endcase
    end

    // Timer restarts on every state change and on each byte while receiving.
    assign clr = (state_d != state_q) || ((state_q == ST_RX) && air_rx_stb_i);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // Received-byte bookkeeping: byte count, destination match, source address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '0;
            hit_q  <= 1'b0;
            src_q  <= 8'h00;
        end else if (state_d != state_q) begin
            rcnt_q <= '0;
        end else if (air_rx_stb_i && ((state_q == ST_RX) || (state_q == ST_WAIT_ACK))) begin
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == '0) hit_q <= (air_rx_byte_i == my_addr_i);
            if (rcnt_q == RC_W'(1)) src_q <= air_rx_byte_i;
        end
    end

    // Contention slot captured when carrier is seen while sensing.
    always_ff @(posedge clk) begin
        if (!rst_n)                                slot_q <= SLOT_W'(1);
        else if ((state_q == ST_SENSE) && cs_i)    slot_q <= lfsr;
    end

    // Byte strobes toward the radio and toward the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            air_tx_stb_o  <= 1'b0;
            air_tx_byte_o <= 8'h00;
            rx_stb_o      <= 1'b0;
            rx_byte_o     <= 8'h00;
        end else begin
            air_tx_stb_o  <= ((state_q == ST_DATA) || (state_q == ST_ACK_TX)) && byte_end;
            air_tx_byte_o <= (state_q == ST_DATA) ? tx_byte_i : ack_byte;
            rx_stb_o      <= (state_q == ST_RX) && air_rx_stb_i && hit_now;
            rx_byte_o     <= air_rx_byte_i;
        end
    end

    // Attempt counting and send outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            try_q  <= '0;
            fail_o <= 1'b0;
            done_o <= 1'b0;
            ok_o   <= 1'b0;
        end else begin
            fail_o <= ack_to;
            ok_o   <= ack_ok;
            done_o <= ack_ok || (ack_to && (try_q == TRY_W'(MAX_TRIES - 1)));
            if (ack_ok || (ack_to && (try_q == TRY_W'(MAX_TRIES - 1)))) try_q <= '0;
            else if (ack_to)                                              try_q <= try_q + 1'b1;
        end
    end

    // Radio controls follow the state.
    assign radio_en_o = (state_q != ST_SLEEP);
    assign tx_on_o    = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_ACK_TX);
    assign air_pre_o  = (state_q == ST_PRE);

    AST_PRE_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |-> (tcnt <= CNT_W'(pre_len_i) + CNT_W'(LISTEN_BITS - 1))); // R4
    AST_BUSY_BLOCKS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SENSE) && cs_i) |=> (state_q == ST_BACKOFF)); // R5
    AST_SLOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |-> (slot_q != '0)); // R5
    AST_ACK_ONLY_IF_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_TX) |-> hit_q); // R9
    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        try_q < TRY_W'(MAX_TRIES)); // R8
    AST_WAKE_IGNORED_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LISTEN) && wake_tick_i && !cs_i && !listen_end) |=> (state_q == ST_LISTEN)); // R3
    AST_SLEEP_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> !rx_stb_o); // R12

endmodule

// File: tb/mac_sync_duty_ctrl_tb.sv
`timescale 1ns/1ps
module mac_sync_duty_ctrl_tb;
    localparam int CPB  = 4;
    localparam int LB   = 2;
    localparam int FB   = 20;
    localparam int AB   = 20;
    localparam logic [7:0] MY  = 8'h33;
    localparam logic [7:0] DST = 8'h5A;
    localparam logic [7:0] SRC = 8'h71;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0, cs = 1'b0, pend = 1'b0;
    logic [7:0] pre_len = 8'd10;
    logic [7:0] tx_idx, tx_byte;
    logic rx_stb_in = 1'b0;
    logic [7:0] rx_byte_in = 8'h00;
    logic air_tx_stb, air_pre, radio_en, tx_on, rx_stb, fail, done, ok;
    logic [7:0] air_tx_byte, rx_byte;

    int total = 0, bad = 0;
    int cyc = 0;
    int wake_at = 0, pre_rise_at = 0, cs_fall_at = 0, fail_at = 0;
    int pre_cyc = 0, en_cyc = 0, txn = 0, fwdn = 0, done_n = 0, ok_n = 0, fail_n = 0;
    int tx_at [64];
    logic [7:0] txlog [64];
    logic [7:0] fwdlog [64];
    logic pre_prev = 1'b0, cs_prev = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] exp_data(input logic [7:0] k);
        return (k == 8'd0) ? DST : 8'(k * 3 + 32);
    endfunction

    assign tx_byte = exp_data(tx_idx);

    mac_sync_duty_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wake_tick_i(wake), .cs_i(cs), .pend_i(pend),
        .pre_len_i(pre_len), .my_addr_i(MY), .tx_idx_o(tx_idx), .tx_byte_i(tx_byte),
        .air_rx_stb_i(rx_stb_in), .air_rx_byte_i(rx_byte_in),
        .air_tx_stb_o(air_tx_stb), .air_tx_byte_o(air_tx_byte), .air_pre_o(air_pre),
        .radio_en_o(radio_en), .tx_on_o(tx_on), .rx_stb_o(rx_stb), .rx_byte_o(rx_byte),
        .fail_o(fail), .done_o(done), .ok_o(ok)
    );

    // Monitor: samples at the falling edge and keeps monotonic tallies.
    always @(negedge clk) begin
        if (wake) wake_at = cyc;
        if (air_pre && !pre_prev) pre_rise_at = cyc;
        if (!cs && cs_prev) cs_fall_at = cyc;
        if (air_pre) pre_cyc++;
        if (radio_en) en_cyc++;
        if (air_tx_stb) begin txlog[txn % 64] = air_tx_byte; tx_at[txn % 64] = cyc; txn++; end
        if (rx_stb) begin fwdlog[fwdn % 64] = rx_byte; fwdn++; end
        if (done) begin done_n++; if (ok) ok_n++; end
        if (fail) begin fail_n++; fail_at = cyc; end
        pre_prev = air_pre;
        cs_prev = cs;
        cyc++;
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    always @(negedge clk) if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, 150000);
        finish_run();
    end

    task automatic check(input bit c, input string req, input int act, input int exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_wake();
        @(posedge clk); #1 wake = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1 rx_stb_in = 1'b1; rx_byte_in = b;
        @(posedge clk); #1 rx_stb_in = 1'b0;
        step(6);
    endtask

    task automatic wait_sleep();
        for (int g = 0; g < 5000 && radio_en; g++) step(1);
        step(4);
    endtask

    task automatic wait_txn(input int target);
        for (int g = 0; g < 5000 && txn < target; g++) step(1);
    endtask

    initial begin
        int b_en, b_pre, b_tx, b_fwd, b_done, b_ok, b_fail, errs, frst;
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1: reset state
        check(radio_en == 1'b0, "R1 radio_en after reset", radio_en, 0);
        check(tx_on == 1'b0 && air_pre == 1'b0, "R1 tx/preamble after reset", tx_on, 0);
        check(txn == 0 && done_n == 0, "R1 no strobes after reset", txn, 0);

        // R2: quiet listen window
        b_en = en_cyc;
        pulse_wake(); step(40);
        check(en_cyc - b_en == LB * CPB, "R2 listen window cycles", en_cyc - b_en, LB * CPB);
        check(radio_en == 1'b0, "R2 sleeps after window", radio_en, 0);

        // R3: second wakeup while awake
        b_en = en_cyc;
        pulse_wake(); step(1);
        pulse_wake(); step(40);
        check(en_cyc - b_en == LB * CPB, "R3 window not extended", en_cyc - b_en, LB * CPB);

        // R12: bytes while asleep
        b_en = en_cyc; b_tx = txn; b_fwd = fwdn;
        send_byte(MY);
        for (int k = 1; k < FB; k++) send_byte(8'(k));
        step(20);
        check(en_cyc == b_en, "R12 radio stays off", en_cyc - b_en, 0);
        check(txn == b_tx && fwdn == b_fwd, "R12 nothing forwarded or sent", fwdn - b_fwd, 0);

        // R4/R6/R7: clean send with acknowledgement
        pre_len = 8'd10; pend = 1'b1;
        b_pre = pre_cyc; b_tx = txn; b_done = done_n; b_ok = ok_n;
        pulse_wake();
        wait_txn(b_tx + FB);
        check(pre_cyc - b_pre == (10 + LB) * CPB, "R4 preamble length", pre_cyc - b_pre, (10 + LB) * CPB);
        check(pre_rise_at - wake_at == LB * CPB + 1, "R4 sense before preamble", pre_rise_at - wake_at, LB * CPB + 1);
        errs = 0; frst = -1;
        for (int k = 0; k < FB; k++)
            if (txlog[(b_tx + k) % 64] != exp_data(8'(k))) begin errs++; if (frst < 0) frst = k; end
        check(errs == 0, "R6 data bytes (mismatch count)", errs, 0);
        check(tx_at[(b_tx + FB - 1) % 64] - tx_at[b_tx % 64] == (FB - 1) * 8 * CPB, "R6 byte spacing",
              tx_at[(b_tx + FB - 1) % 64] - tx_at[b_tx % 64], (FB - 1) * 8 * CPB);
        send_byte(MY);
        for (int k = 1; k < AB; k++) send_byte(8'h00);
        step(4);
        check(done_n - b_done == 1 && ok_n - b_ok == 1, "R7 acknowledged outcome", ok_n - b_ok, 1);
        pend = 1'b0;
        wait_sleep();

        // R5/R8: busy channel, then three unacknowledged attempts
        pre_len = 8'd6; pend = 1'b1; cs = 1'b1;
        b_pre = pre_cyc; b_fail = fail_n; b_done = done_n; b_ok = ok_n;
        pulse_wake(); step(40);
        cs = 1'b0;
        step(1);
        check(pre_cyc == b_pre, "R5 no preamble while busy", pre_cyc - b_pre, 0);
        b_tx = txn;
        wait_txn(b_tx + FB);
        check(pre_rise_at - cs_fall_at >= LB * CPB && pre_rise_at - cs_fall_at <= (15 + LB) * CPB + 4,
              "R5 deferral bound", pre_rise_at - cs_fall_at, LB * CPB);
        check(pre_cyc - b_pre == (6 + LB) * CPB, "R4 preamble length short", pre_cyc - b_pre, (6 + LB) * CPB);
        step(700);
        check(fail_at - tx_at[(b_tx + FB - 1) % 64] == (AB * 8 + 4) * CPB, "R8 ack timeout",
              fail_at - tx_at[(b_tx + FB - 1) % 64], (AB * 8 + 4) * CPB);
        check(done_n == b_done, "R8 no outcome after first failure", done_n - b_done, 0);
        pulse_wake(); wait_txn(b_tx + 2 * FB); step(700);
        pulse_wake(); wait_txn(b_tx + 3 * FB); step(700);
        check(fail_n - b_fail == 3, "R8 three failed attempts", fail_n - b_fail, 3);
        check(done_n - b_done == 1 && ok_n == b_ok, "R8 final outcome not ok", done_n - b_done, 1);
        pend = 1'b0;
        wait_sleep();

        // R9: frame addressed to this node
        b_fwd = fwdn; b_tx = txn;
        @(posedge clk); #1 wake = 1'b1; cs = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
        step(4); cs = 1'b0;
        send_byte(MY); send_byte(SRC);
        for (int k = 2; k < FB; k++) send_byte(8'(k + 16));
        wait_txn(b_tx + AB);
        errs = 0;
        for (int k = 0; k < FB; k++)
            if (fwdlog[(b_fwd + k) % 64] != ((k == 0) ? MY : (k == 1) ? SRC : 8'(k + 16))) errs++;
        check(fwdn - b_fwd == FB && errs == 0, "R9 forwarded frame", fwdn - b_fwd, FB);
        errs = 0;
        for (int k = 0; k < AB; k++)
            if (txlog[(b_tx + k) % 64] != ((k == 0) ? SRC : (k == 1) ? MY : 8'h00)) errs++;
        check(txn - b_tx == AB && errs == 0, "R9 ack content", errs, 0);
        wait_sleep();

        // R10: overheard frame
        b_fwd = fwdn; b_tx = txn;
        @(posedge clk); #1 wake = 1'b1; cs = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
        step(4); cs = 1'b0;
        send_byte(8'h44); send_byte(SRC);
        for (int k = 2; k < FB; k++) send_byte(8'(k));
        check(radio_en == 1'b0, "R10 sleeps after overheard frame", radio_en, 0);
        step(700);
        check(fwdn == b_fwd && txn == b_tx, "R10 no forward and no ack", txn - b_tx, 0);

        // R11: receive gap timeout
        b_en = en_cyc;
        @(posedge clk); #1 wake = 1'b1; cs = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
        step(4); cs = 1'b0;
        step(1300);
        check(en_cyc - b_en == 1 + (256 + LB + 16) * CPB, "R11 gap timeout", en_cyc - b_en, 1 + (256 + LB + 16) * CPB);

        finish_run();
    end
endmodule